// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects 64 level-sensitive interrupt sources and routes them to up to four CPUs, each of which gets one IRQ line. A source has to clear two gates before it can reach a CPU. The first gate is a single global enable per source. The second gate is a mask bit held separately for every CPU.

Shared sources also carry a per-source affinity word. That word chooses which CPUs the source is allowed to interrupt. The low-numbered sources are private to each CPU. Every CPU drives its own level inputs for them, and affinity does not apply to them.

Software never edits a bitmap directly. Instead it writes a source number to a "set" register or a "clear" register. A small register bus selects one of two apertures:

- The global aperture holds the enable set/clear registers, the affinity words and a read-only register that reports the source count.
- The per-CPU aperture holds the mask set/clear registers and an acknowledge register. A `busCpuId` input tells the block which CPU's copy is being accessed.

Reading the acknowledge register returns the lowest-numbered source that can currently interrupt that CPU, or 1023 when none can. The read has no side effect, because each source is cleared at its device.

Top module: `irqc_top`

## Requirements
- R1: After reset, every source is globally disabled, masked on every CPU, and has an affinity field of zero. As a result all `irq` lines are low and acknowledge reads return 1023.
- R2: A read of global offset 0x000 returns the number of implemented sources (64) in bits [11:2] and zero in all other bits.
- R3: Writing a source number n to global offset 0x030 enables n globally, and writing it to global offset 0x034 disables it. A written value of 64 or more changes nothing.
- R4: Writing n to per-CPU offset 0x048 masks n for the CPU given by `busCpuId`, and writing n to per-CPU offset 0x04C unmasks it. The mask state of the other CPUs is unaffected. A value of 64 or more changes nothing.
- R5: Source n has an affinity word at global offset 0x100 + 4·n. Bits [3:0] hold one enable bit per CPU (bit c for CPU c) and read back as written. All other bits read as zero.
- R6: A shared source n (29..63) can interrupt CPU c exactly when all of these hold:
  - `srcLevel[n]` is high;
  - n is globally enabled;
  - affinity bit c of n is set;
  - n is unmasked for CPU c.
- R7: A private source n (0..28) can interrupt CPU c exactly when all of these hold:
  - `pcLevel[c*29+n]` is high;
  - n is globally enabled;
  - n is unmasked for CPU c.

  Affinity bits have no effect on private sources, and `srcLevel[28:0]` is ignored.
- R8: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source that can interrupt the CPU given by `busCpuId`, or 1023 if there is none. All upper bits are zero, and the read changes no state.
- R9: `irq[c]` is high exactly when at least one source can interrupt CPU c. It reflects a level or register change no later than one clock after that change.
- R10: Read data appears on `busRdData` in the cycle after the read strobe and holds until the next read. A read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busPerCpu | input | 1 | 1 selects the per-CPU aperture, 0 selects the global aperture |
| busCpuId | input | 2 | CPU whose per-CPU registers are accessed |
| busAddr | input | 12 | Byte offset within the selected aperture |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| srcLevel | input | 64 | Shared source levels; bits 28:0 are unused |
| pcLevel | input | 116 | Private source levels, 29 per CPU, CPU c at bits [c*29 +: 29] |
| irq | output | 4 | Interrupt line per CPU |

## Verification
The hardest situation to reach is a source that is eligible for one CPU but blocked for another. This needs a level input, the global enable, an affinity bit and a per-CPU unmask all lined up at the same time, and pure random writes across 64 sources and 4 CPUs seldom achieve that.

The random stimulus therefore draws half of its source numbers from a small pool that straddles the private/shared boundary. Repeated set/clear writes on those numbers soon leave each one in a mixed state. The stimulus also writes out-of-range values whose low bits alias a real source, and checks after each one that no line or acknowledge value moved.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ACK_W   = 10;
  localparam int NONE_ID = 1023;
  localparam int MAX_CPU = 4;

  localparam int OFS_CTL     = 'h000;
  localparam int OFS_EN_SET  = 'h030;
  localparam int OFS_EN_CLR  = 'h034;
  localparam int OFS_ACK     = 'h044;
  localparam int OFS_MSK_SET = 'h048;
  localparam int OFS_MSK_CLR = 'h04C;
  localparam int OFS_AFF     = 'h100;

  typedef struct packed {
    logic               enSet;
    logic               enClr;
    logic               mskSet;
    logic               mskClr;
    logic               affWr;
    logic               rdCtl;
    logic               rdAck;
    logic               rdAff;
    logic               rdZero;
    logic [ACK_W-1:0]   idx;
    logic [MAX_CPU-1:0] affVal;
  } irqc_strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busPerCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output irqc_strobe_t      strb
);
  localparam logic [ADDR_W-1:0] AFF_LO = ADDR_W'(OFS_AFF);
  localparam logic [ADDR_W-1:0] AFF_HI = ADDR_W'(OFS_AFF + 4 * NUM_SRC);

  logic              wrOk;
  logic              affHit;
  logic [ADDR_W-1:0] affOff;

  assign wrOk   = busWrData < DATA_W'(NUM_SRC);
  assign affOff = busAddr - AFF_LO;
  assign affHit = (busAddr >= AFF_LO) && (busAddr < AFF_HI) && (busAddr[1:0] == 2'b00);

  always_comb begin
    strb        = '0;
    strb.affVal = busWrData[MAX_CPU-1:0];
    if (affHit) strb.idx = ACK_W'(affOff >> 2);
    else        strb.idx = busWrData[ACK_W-1:0];

    if (busWr) begin
      if (!busPerCpu) begin
        if (busAddr == ADDR_W'(OFS_EN_SET) && wrOk) strb.enSet = 1'b1;
        if (busAddr == ADDR_W'(OFS_EN_CLR) && wrOk) strb.enClr = 1'b1;
        if (affHit)                                 strb.affWr = 1'b1;
      end else begin
        if (busAddr == ADDR_W'(OFS_MSK_SET) && wrOk) strb.mskSet = 1'b1;
        if (busAddr == ADDR_W'(OFS_MSK_CLR) && wrOk) strb.mskClr = 1'b1;
      end
    end

    if (busRd) begin
      if (!busPerCpu) begin
        if (busAddr == ADDR_W'(OFS_CTL)) strb.rdCtl  = 1'b1;
        else if (affHit)                 strb.rdAff  = 1'b1;
        else                             strb.rdZero = 1'b1;
      end else begin
        if (busAddr == ADDR_W'(OFS_ACK)) strb.rdAck  = 1'b1;
        else                             strb.rdZero = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int NUM_CPU    = 4,
  parameter int PERCPU_CNT = 29,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  irqc_strobe_t                  strb,
  input  logic [$clog2(NUM_CPU)-1:0]    cpuSel,
  input  logic [NUM_SRC-1:0]            srcLevel,
  input  logic [NUM_CPU*PERCPU_CNT-1:0] pcLevel,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_CPU-1:0]            irq
);
  localparam int SRC_W = $clog2(NUM_SRC);
  localparam logic [NUM_SRC-1:0] SHARED_MASK = {NUM_SRC{1'b1}} << PERCPU_CNT;

  logic [NUM_SRC-1:0] gEn;
  logic [NUM_SRC-1:0] mask [NUM_CPU];
  logic [NUM_CPU-1:0] aff  [NUM_SRC];

  logic [SRC_W-1:0]   wIdx;
  logic [NUM_SRC-1:0] sharedLv;

  logic [NUM_CPU-1:0][NUM_SRC-1:0] affCol;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] elig;
  logic [NUM_CPU-1:0][ACK_W-1:0]   ackId;

  assign wIdx     = strb.idx[SRC_W-1:0];
  assign sharedLv = srcLevel & SHARED_MASK;

  function automatic logic [ACK_W-1:0] lowestId(input logic [NUM_SRC-1:0] v);
    lowestId = ACK_W'(NONE_ID);
    for (int n = NUM_SRC - 1; n >= 0; n--)
      if (v[n]) lowestId = ACK_W'(n);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      gEn <= '0;
      for (int c = 0; c < NUM_CPU; c++) mask[c] <= '1;
      for (int n = 0; n < NUM_SRC; n++) aff[n] <= '0;
    end else begin
      if (strb.enSet)  gEn[wIdx]          <= 1'b1;
      if (strb.enClr)  gEn[wIdx]          <= 1'b0;
      if (strb.mskSet) mask[cpuSel][wIdx] <= 1'b1;
      if (strb.mskClr) mask[cpuSel][wIdx] <= 1'b0;
      if (strb.affWr)  aff[wIdx]          <= strb.affVal[NUM_CPU-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SRC-1:0] lv;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n < PERCPU_CNT) begin : g_priv
        assign affCol[c][n] = 1'b1;
      end else begin : g_shr
        assign affCol[c][n] = aff[n][c];
      end
    end
    assign lv       = sharedLv | {{(NUM_SRC-PERCPU_CNT){1'b0}}, pcLevel[c*PERCPU_CNT +: PERCPU_CNT]};
    assign elig[c]  = lv & gEn & ~mask[c] & affCol[c];
    assign ackId[c] = lowestId(elig[c]);
    assign irq[c]   = |elig[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdCtl) begin
      rdData <= DATA_W'(NUM_SRC) << 2;
    end else if (strb.rdAck) begin
      rdData <= DATA_W'(ackId[cpuSel]);
    end else if (strb.rdAff) begin
      rdData <= DATA_W'(aff[wIdx]);
    end else if (strb.rdZero) begin
      rdData <= '0;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gEn == '0 && irq == '0));

  // R3
  enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.enClr && !strb.enSet) |=> !gEn[$past(wIdx)]);

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.mskSet && !strb.mskClr) |=> mask[$past(cpuSel)][$past(wIdx)]);

  // R9
  ack_irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rdAck |=> ((rdData == DATA_W'(NONE_ID)) == !$past(irq[cpuSel])));

  // R8
  ack_range_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rdAck |=> (rdData == DATA_W'(NONE_ID) || rdData < DATA_W'(NUM_SRC)));

  // R7
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (sharedLv == '0 && pcLevel == '0) |-> (irq == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int NUM_CPU    = 4,
  parameter int PERCPU_CNT = 29,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          busWr,
  input  logic                          busRd,
  input  logic                          busPerCpu,
  input  logic [$clog2(NUM_CPU)-1:0]    busCpuId,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  input  logic [NUM_SRC-1:0]            srcLevel,
  input  logic [NUM_CPU*PERCPU_CNT-1:0] pcLevel,
  output logic [NUM_CPU-1:0]            irq
);
  irqc_strobe_t strb;

  irqc_ctrl #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .busWr    (busWr),
    .busRd    (busRd),
    .busPerCpu(busPerCpu),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .strb     (strb)
  );

  irqc_datapath #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CPU   (NUM_CPU),
    .PERCPU_CNT(PERCPU_CNT),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .cpuSel  (busCpuId),
    .srcLevel(srcLevel),
    .pcLevel (pcLevel),
    .rdData  (busRdData),
    .irq     (irq)
  );
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int NS = 64;
  localparam int NC = 4;
  localparam int PC = 29;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              busWr = 1'b0, busRd = 1'b0, busPerCpu = 1'b0;
  logic [1:0]        busCpuId = '0;
  logic [11:0]       busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NS-1:0]     srcLevel = '0;
  logic [NC*PC-1:0]  pcLevel = '0;
  logic [NC-1:0]     irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          gM [NS];
  bit          mM [NC][NS];
  logic [3:0]  aM [NS];

  always #5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busPerCpu(busPerCpu),
    .busCpuId(busCpuId), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .srcLevel(srcLevel), .pcLevel(pcLevel), .irq(irq)
  );

  function automatic int expAck(input int c);
    for (int n = 0; n < NS; n++) begin
      bit lv, af;
      lv = (n < PC) ? pcLevel[c*PC+n] : srcLevel[n];
      af = (n < PC) ? 1'b1 : aM[n][c];
      if (lv && gM[n] && !mM[c][n] && af) return n;
    end
    return 1023;
  endfunction

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = (expAck(c) != 1023);
    return r;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busW(input bit pc, input int cpu, input int addr, input int data);
    @(negedge clk);
    busWr = 1'b1; busPerCpu = pc; busCpuId = 2'(cpu); busAddr = 12'(addr); busWrData = 32'(data);
    @(negedge clk);
    busWr = 1'b0;
    if (!pc && addr == 'h30 && data >= 0 && data < NS) gM[data] = 1;
    if (!pc && addr == 'h34 && data >= 0 && data < NS) gM[data] = 0;
    if (pc && addr == 'h48 && data >= 0 && data < NS) mM[cpu][data] = 1;
    if (pc && addr == 'h4C && data >= 0 && data < NS) mM[cpu][data] = 0;
    if (!pc && addr >= 'h100 && addr < 'h100 + 4*NS && addr % 4 == 0) aM[(addr-'h100)/4] = 4'(data);
  endtask

  task automatic busR(input bit pc, input int cpu, input int addr, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busPerCpu = pc; busCpuId = 2'(cpu); busAddr = 12'(addr);
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic chkAck(input string req, input int c);
    logic [31:0] d;
    busR(1, c, 'h44, d);
    chk(req, d, expAck(c));
  endtask

  function automatic int pickSrc();
    int pool [8] = '{0, 5, 28, 29, 30, 31, 40, 63};
    int r = $urandom % 10;
    if (r < 5) return pool[$urandom % 8];
    if (r == 9) return NS + ($urandom % 960);
    return $urandom % NS;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    for (int n = 0; n < NS; n++) begin
      gM[n] = 0; aM[n] = '0;
      for (int c = 0; c < NC; c++) mM[c][n] = 1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    srcLevel = '1; pcLevel = '1;
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    chkAck("R1 ack after reset", 0);
    busR(0, 0, 'h100 + 4*40, d);
    chk("R1 affinity after reset", d, 0);
    srcLevel = '0; pcLevel = '0;

    // R2
    busR(0, 0, 'h000, d);
    chk("R2 control register", d, 32'h100);

    // R10: unmapped and write-only offsets read zero
    busR(0, 0, 'h200, d);
    chk("R10 unmapped global", d, 0);
    busR(1, 2, 'h48, d);
    chk("R10 per-CPU set reg reads zero", d, 0);

    // R5
    busW(0, 0, 'h100 + 4*40, 32'hFFFF_FFF4);
    busR(0, 0, 'h100 + 4*40, d);
    chk("R5 affinity readback", d, 32'h4);
    @(negedge clk);
    chk("R10 read data held", busRdData, 32'h4);

    // R6: source 40 to CPU 2 only
    srcLevel[40] = 1'b1;
    busW(0, 0, 'h30, 40);
    busW(1, 2, 'h4C, 40);
    @(negedge clk);
    chk("R6 irq shared to cpu2", irq, 4'b0100);
    chkAck("R6 ack cpu2", 2);
    chkAck("R6 ack cpu1 none", 1);
    busW(0, 0, 'h100 + 4*40, 0);
    chk("R6 affinity removed", irq, 0);

    // R3: out-of-range enable aliasing 36 (100 = 36 + 64) is ignored
    srcLevel[36] = 1'b1;
    busW(0, 0, 'h100 + 4*36, 1);
    busW(1, 0, 'h4C, 36);
    busW(0, 0, 'h30, 100);
    @(negedge clk);
    chk("R3 out-of-range enable ignored", irq, 0);
    busW(0, 0, 'h30, 36);
    chk("R3 enable", irq, 4'b0001);
    busW(0, 0, 'h34, 36);
    chk("R3 disable", irq, 0);

    // R7: private source 5
    srcLevel[5] = 1'b1;
    busW(0, 0, 'h30, 5);
    busW(1, 1, 'h4C, 5);
    @(negedge clk);
    chk("R7 shared bits ignored for private", irq, 0);
    pcLevel[1*PC+5] = 1'b1;
    pcLevel[3*PC+5] = 1'b1;
    @(negedge clk);
    chk("R7 private to cpu1 only", irq, 4'b0010);
    chkAck("R7 ack cpu1", 1);

    // R8: read twice, no side effect
    busR(1, 1, 'h44, d);
    chk("R8 ack repeat", d, 5);
    chk("R8 irq unchanged by ack", irq, 4'b0010);

    // R4: mask on cpu1 only, cpu3 unmasked separately
    busW(1, 3, 'h4C, 5);
    chk("R4 unmask cpu3", irq, 4'b1010);
    busW(1, 1, 'h48, 5);
    chk("R4 mask cpu1 leaves cpu3", irq, 4'b1000);
    busW(1, 3, 'h48, 69);
    chk("R4 out-of-range mask ignored", irq, 4'b1000);

    // R9 / R8 random phase
    for (int it = 0; it < 1500; it++) begin
      int op = $urandom % 9;
      int n  = pickSrc();
      int c  = $urandom % NC;
      case (op)
        0: busW(0, 0, 'h30, n);
        1: busW(0, 0, 'h34, n);
        2: busW(1, c, 'h4C, n);
        3: busW(1, c, 'h48, n);
        4: if (n < NS) busW(0, 0, 'h100 + 4*n, $urandom);
        5: begin srcLevel = {$urandom, $urandom} & {$urandom, $urandom}; @(negedge clk); end
        6: begin
             pcLevel = {$urandom, $urandom, $urandom, $urandom};
             pcLevel = pcLevel & {$urandom, $urandom, $urandom, $urandom};
             @(negedge clk);
           end
        7: chkAck("R8 random ack", c);
        default: if (n < NS) begin
             busR(0, 0, 'h100 + 4*n, d);
             chk("R5 random affinity", d, aM[n]);
           end
      endcase
      chk("R9 random irq", irq, expIrq());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule